// File: doc/BRIEF.md
# Daisy-Chain Frame Transmitter

This block sits on the host side of a serial chain of LED-driver nodes. It takes one 31-bit word per node from a valid/ready input. It shifts each word out most significant bit first, on a serial clock and data pair that it derives from the system clock. When the last word of the frame has gone out, it waits for a setup interval and then pulses the latch line. The setup interval grows with the length of the chain, because the latch travels down the chain on a path whose delay differs from the clock path.

The host supplies the word for the farthest node first. The block only keeps the order in which it accepts words. The node count, the clock half-period and the per-node latch delay are run-time inputs. They are sampled when a frame or a restart sequence begins. The block also drives the active-low output-enable line.

On request, the block runs a restart sequence:
- It blanks the outputs.
- It issues one serial clock rising edge while the outputs are blanked, which restarts the PWM cycle of every node.
- It then releases the enable line to the host's setting.

Top module: `chain_frame_tx`

## Requirements
- R1: Every accepted word is sent as 31 bits, bit 30 first and bit 0 last, one bit per rising edge of `sclk`. Words go out in the order they were accepted.
- R2: Within a word, `sclk` rises once every 2·H system cycles, where H is `cfg_half` with 0 treated as 1. `sdata` equals its value of the previous cycle at every `sclk` rising edge, and it does not change while `sclk` stays high.
- R3: A frame has N words, where N is `cfg_nodes` clamped to the range 1..250, and exactly 31·N `sclk` rising edges. Once the N-th word is accepted, `in_ready` stays low until the latch pulse has ended and `busy` is low again.
- R4: The latch rises no earlier than BASE_DLY + N·`cfg_node_dly` system cycles after the last `sclk` rising edge of the frame. The latch rises exactly once per frame.
- R5: `latch` is low at every rising edge of `sclk`.
- R6: In a word whose bit 30 is 1, bits 29 and 28 are sent as 0. In a word whose bit 30 is 0, all 31 bits are sent unchanged.
- R7: `busy` is high from the cycle after the first word of a frame is accepted until the latch pulse ends, and it is high while `latch` is high.
- R8: A `restart_req` pulse while idle does three things: it holds `oe_n` high for the whole sequence, it produces exactly one `sclk` rising edge, and it returns `oe_n` to the inverse of `en_req`. It produces no latch pulse.
- R9: Outside a restart sequence, `oe_n` follows the inverse of `en_req` one cycle later.
- R10: A `restart_req` raised while a frame is in progress is ignored: the frame has no extra `sclk` edge and `oe_n` does not rise.
- R11: After reset, `sclk`, `latch` and `busy` are low, `oe_n` is high and `in_ready` is high.
- R12: Changes to `cfg_half`, `cfg_nodes` or `cfg_node_dly` after a frame has started do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nodes | input | CFG_W | Number of nodes in the chain (clamped 1..MAX_NODES) |
| cfg_half | input | CFG_W | Serial clock half-period in system cycles (0 acts as 1) |
| cfg_node_dly | input | CFG_W | Extra latch setup cycles per node |
| in_valid | input | 1 | A node word is offered |
| in_ready | output | 1 | The offered word is taken at this edge |
| in_word | input | 31 | Node word; bit 30 selects the word type |
| en_req | input | 1 | Host wants node outputs enabled |
| restart_req | input | 1 | Request for a PWM restart sequence |
| sclk | output | 1 | Serial clock to the first node |
| sdata | output | 1 | Serial data to the first node |
| latch | output | 1 | Latch pulse to the first node |
| oe_n | output | 1 | Active-low output enable to the first node |
| busy | output | 1 | Frame or restart sequence in progress |

## Verification
The bench targets four kinds of error:
- A setup delay that leaves out the per-node term would latch before the data reaches the far end. The bench checks the measured latch gap against the full requirement for a chain longer than one node.
- Node-count clamping is tested at zero and above 250. A design that does not clamp would stall waiting for words, or latch after the wrong word.
- The test-bit scrubbing must depend on bit 30. A wrong mask would corrupt data words, or pass the test bits through.
- A restart issued during a frame, and configuration changes made mid-frame, must leave the frame intact. A design that gets either wrong shows extra clock edges, a blanked enable line or a changed bit period.

// File: rtl/chain_tx_pkg.sv
package chain_tx_pkg;

  localparam int unsigned WORD_W  = 31;
  localparam int unsigned SEL_BIT = 30;  // word-type selector decoded by the nodes
  localparam int unsigned TB_HI   = 29;  // reserved test field, high bit
  localparam int unsigned TB_LO   = 28;  // reserved test field, low bit

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_NEXT,
    ST_SETUP,
    ST_LATCH,
    ST_RS_LO,
    ST_RS_HI,
    ST_RS_TL
  } tx_state_e;

  // Node count actually used for a frame.
  function automatic int unsigned clamp_nodes(int unsigned req, int unsigned max_n);
    if (req == 0) return 1;
    if (req > max_n) return max_n;
    return req;
  endfunction

  // Half-period of the serial clock; zero is promoted to one cycle.
  function automatic int unsigned eff_half(int unsigned h);
    return (h == 0) ? 1 : h;
  endfunction

  // Minimum gap from the last serial clock rise to the latch rise.
  function automatic int unsigned setup_cycles(int unsigned base, int unsigned n,
                                               int unsigned per);
    return base + n * per;
  endfunction

  // Clear the reserved test field of configuration words.
  function automatic logic [WORD_W-1:0] scrub(logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    if (w[SEL_BIT]) begin
      r[TB_HI] = 1'b0;
      r[TB_LO] = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/chain_tx_halfcnt.sv
module chain_tx_halfcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] half,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = !clr && (cnt == half - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || tick) cnt <= '0;
    else                       cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/chain_tx_shreg.sv
module chain_tx_shreg #(
  parameter int unsigned WORD_W = 31,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic              msb,
  output logic              last
);
  logic [WORD_W-1:0] sr;
  logic [IDX_W-1:0]  bidx;

  assign msb  = sr[WORD_W-1];
  assign last = (bidx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      bidx <= '0;
    end else if (load) begin
      sr   <= din;
      bidx <= IDX_W'(WORD_W - 1);
    end else if (shift) begin
      sr   <= {sr[WORD_W-2:0], 1'b0};
      bidx <= bidx - IDX_W'(1);
    end
  end
endmodule

// File: rtl/chain_tx_setupdly.sv
module chain_tx_setupdly #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] target,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= target;
    else if (!done) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/chain_frame_tx.sv
module chain_frame_tx
  import chain_tx_pkg::*;
#(
  parameter int unsigned MAX_NODES = 250,
  parameter int unsigned CFG_W     = 8,
  parameter int unsigned BASE_DLY  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_nodes,
  input  logic [CFG_W-1:0]  cfg_half,
  input  logic [CFG_W-1:0]  cfg_node_dly,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [30:0]       in_word,
  input  logic              en_req,
  input  logic              restart_req,
  output logic              sclk,
  output logic              sdata,
  output logic              latch,
  output logic              oe_n,
  output logic              busy
);
  localparam int unsigned NODE_W = $clog2(MAX_NODES + 1);
  localparam int unsigned DLY_W  = $clog2(BASE_DLY + MAX_NODES * ((1 << CFG_W) - 1) + 1);

  tx_state_e st, st_n;
  logic ph, ph_n;
  logic [NODE_W-1:0] node_cnt, n_snap;
  logic [CFG_W-1:0]  h_snap, per_snap;
  logic half_done, cnt_clr, bit_last, load_en, shift_en, dly_load, dly_done;
  logic snap_en;

  // Named internal events used by the checker.
  logic [DLY_W-1:0] setup_need;
  logic             rs_active;

  assign setup_need = DLY_W'(setup_cycles(BASE_DLY, 32'(n_snap), 32'(per_snap)));
  assign rs_active  = (st == ST_RS_LO) || (st == ST_RS_HI) || (st == ST_RS_TL);
  assign in_ready   = ((st == ST_IDLE) && !restart_req) || (st == ST_NEXT);
  assign cnt_clr    = (st == ST_IDLE) || (st == ST_NEXT) || (st == ST_SETUP);
  assign snap_en    = (st == ST_IDLE) && (restart_req || in_valid);

  chain_tx_halfcnt #(.W(CFG_W)) u_half (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .half(h_snap), .tick(half_done)
  );

  chain_tx_shreg #(.WORD_W(WORD_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .load(load_en), .shift(shift_en),
    .din(scrub(in_word)), .msb(sdata), .last(bit_last)
  );

  chain_tx_setupdly #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .target(setup_need), .done(dly_done)
  );

  always_comb begin
    st_n     = st;
    ph_n     = ph;
    load_en  = 1'b0;
    shift_en = 1'b0;
    dly_load = 1'b0;
    unique case (st)
      ST_IDLE: begin
        ph_n = 1'b0;
        if (restart_req) st_n = ST_RS_LO;
        else if (in_valid) begin
          load_en = 1'b1;
          st_n    = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (half_done) begin
          if (!ph) ph_n = 1'b1;
          else begin
            ph_n = 1'b0;
            if (!bit_last) shift_en = 1'b1;
            else if (node_cnt == n_snap) begin
              st_n     = ST_SETUP;
              dly_load = 1'b1;
            end else st_n = ST_NEXT;
          end
        end
      end
      ST_NEXT: begin
        if (in_valid) begin
          load_en = 1'b1;
          st_n    = ST_SHIFT;
        end
      end
      ST_SETUP: if (dly_done) st_n = ST_LATCH;
      ST_LATCH: if (half_done) st_n = ST_IDLE;
      ST_RS_LO: if (half_done) st_n = ST_RS_HI;
      ST_RS_HI: if (half_done) st_n = ST_RS_TL;
      ST_RS_TL: if (half_done) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= 1'b0;
      node_cnt <= '0;
      n_snap   <= NODE_W'(1);
      h_snap   <= CFG_W'(1);
      per_snap <= '0;
      sclk     <= 1'b0;
      latch    <= 1'b0;
      busy     <= 1'b0;
      oe_n     <= 1'b1;
    end else begin
      st    <= st_n;
      ph    <= ph_n;
      sclk  <= ((st_n == ST_SHIFT) && ph_n) || (st_n == ST_RS_HI);
      latch <= (st_n == ST_LATCH);
      busy  <= (st_n != ST_IDLE);
      oe_n  <= !en_req || (st_n == ST_RS_LO) || (st_n == ST_RS_HI) || (st_n == ST_RS_TL);
      if (snap_en) begin
        n_snap   <= NODE_W'(clamp_nodes(32'(cfg_nodes), MAX_NODES));
        h_snap   <= CFG_W'(eff_half(32'(cfg_half)));
        per_snap <= cfg_node_dly;
      end
      if (load_en) node_cnt <= (st == ST_IDLE) ? NODE_W'(1) : node_cnt + NODE_W'(1);
    end
  end

endmodule

// File: rtl/chain_tx_chk.sv
module chain_tx_chk #(
  parameter int unsigned DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             sdata,
  input logic             latch,
  input logic             oe_n,
  input logic             busy,
  input logic             in_ready,
  input logic             rs_active,
  input logic [DLY_W-1:0] setup_need
);
  localparam int unsigned GAP_W = DLY_W + 1;

  logic [GAP_W-1:0] gap;
  logic             sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= '1;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (sclk && !sclk_d) gap <= GAP_W'(1);
      else if (gap != '1)  gap <= gap + GAP_W'(1);
    end
  end

  // R5
  latch_low_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !latch);

  // R2
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));

  // R4
  latch_setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> (gap >= {1'b0, setup_need}));

  // R7
  busy_during_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> busy);

  // R8
  restart_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_active |-> oe_n);

  // R3
  ready_quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!sclk && !latch));

endmodule

bind chain_frame_tx chain_tx_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .latch(latch),
  .oe_n(oe_n), .busy(busy), .in_ready(in_ready), .rs_active(rs_active),
  .setup_need(setup_need)
);

// File: tb/chain_frame_tx_bench.sv
module chain_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_nodes = 8'd1, cfg_half = 8'd1, cfg_node_dly = 8'd0;
  logic in_valid = 1'b0, en_req = 1'b1, restart_req = 1'b0;
  logic [30:0] in_word = '0;
  logic in_ready, sclk, sdata, latch, oe_n, busy;

  chain_frame_tx #(.MAX_NODES(250), .CFG_W(8), .BASE_DLY(BASE)) u_chain_frame_tx (
    .clk(clk), .rst_n(rst_n), .cfg_nodes(cfg_nodes), .cfg_half(cfg_half),
    .cfg_node_dly(cfg_node_dly), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .en_req(en_req), .restart_req(restart_req),
    .sclk(sclk), .sdata(sdata), .latch(latch), .oe_n(oe_n), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [30:0] tx_mem [0:255];
  logic [30:0] rx_mem [0:255];
  int rx_cnt, rises, latches, rs_rises, spacing_err, setup_err, hold_err;
  int latch_rise_err, oe_hi_cycles, since_rise, last_gap, exp_period, bitpos;
  logic p_sclk = 1'b0, p_latch = 1'b0, p_sdata = 1'b0, hold_val = 1'b0;
  logic [30:0] cap;

  function automatic logic [30:0] expect_word(logic [30:0] w);
    return w[30] ? (w & ~(31'h3 << 28)) : w;
  endfunction

  // Line monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (oe_n) oe_hi_cycles++;
      if (sclk && !p_sclk) begin
        rises++;
        if (oe_n) rs_rises++;
        if (latch) latch_rise_err++;
        if (sdata !== p_sdata) setup_err++;
        if (bitpos != 0 && exp_period != 0 && since_rise != exp_period) spacing_err++;
        since_rise = 0;
        hold_val = sdata;
        cap = {cap[29:0], sdata};
        if (bitpos == 30) begin
          rx_mem[rx_cnt[7:0]] = cap;
          rx_cnt++;
          bitpos = 0;
        end else bitpos++;
      end else if (sclk && p_sclk && sdata !== hold_val) hold_err++;
      if (latch && !p_latch) begin
        latches++;
        last_gap = since_rise;
      end
    end
    p_sclk = sclk;
    p_latch = latch;
    p_sdata = sdata;
  end

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(string req, int act, int lo, string what);
    n_chk++;
    if (act < lo) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected at least %0d", req, what, act, lo);
    end
  endtask

  task automatic clear_mon(int period);
    @(posedge clk);
    rx_cnt = 0; rises = 0; latches = 0; rs_rises = 0; spacing_err = 0;
    setup_err = 0; hold_err = 0; latch_rise_err = 0; oe_hi_cycles = 0;
    since_rise = 0; last_gap = 0; bitpos = 0; cap = '0; exp_period = period;
    @(negedge clk);
  endtask

  task automatic send_words(int n);
    for (int i = 0; i < n; i++) begin
      in_word  = tx_mem[i];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int word_mismatches(int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (rx_mem[i] !== expect_word(tx_mem[i])) bad++;
    return bad;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R11", sclk, 0, "sclk after reset");
    chk("R11", latch, 0, "latch after reset");
    chk("R11", busy, 0, "busy after reset");
    chk("R11", oe_n, 1, "oe_n after reset");
    chk("R11", in_ready, 1, "in_ready after reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_single();
    cfg_nodes = 8'd1; cfg_half = 8'd1; cfg_node_dly = 8'd0;
    tx_mem[0] = 31'h2AC3_5A96;
    clear_mon(2);
    send_words(1);
    chk("R7", busy, 1, "busy after first word");
    wait_idle();
    chk("R1", word_mismatches(1), 0, "single word bits");
    chk("R3", rises, 31, "rising edges, one node");
    chk("R4", latches, 1, "latch pulses, one node");
    chk_ge("R4", last_gap, BASE, "latch gap, one node");
    chk("R2", setup_err + hold_err, 0, "data stability around sclk rise");
    chk("R2", spacing_err, 0, "sclk period H=1");
    chk("R5", latch_rise_err, 0, "latch high at sclk rise");
    chk("R7", busy, 0, "busy after latch");
  endtask

  task automatic t_multi();
    cfg_nodes = 8'd3; cfg_half = 8'd3; cfg_node_dly = 8'd4;
    tx_mem[0] = 31'h7123_4567;
    tx_mem[1] = 31'h3FED_CBA9;
    tx_mem[2] = 31'h4000_0001;
    clear_mon(6);
    send_words(3);
    in_word = 31'h1111_1111; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    chk("R3", busy, 0, "busy when ready returns after last word");
    chk("R3", latches, 1, "latch done before ready returns");
    in_valid = 1'b0;
    wait_idle();
    chk("R3", rx_cnt, 3, "words in three-node frame");
    chk("R1", word_mismatches(3), 0, "word order and bits");
    chk("R6", int'(rx_mem[0][29:28]), 0, "test bits cleared, bit30=1");
    chk("R6", int'(rx_mem[1][29:28]), 3, "test bits kept, bit30=0");
    chk("R2", spacing_err, 0, "sclk period H=3");
    chk_ge("R4", last_gap, BASE + 3 * 4, "latch gap, three nodes");
    chk("R5", latch_rise_err, 0, "latch high at sclk rise");
  endtask

  task automatic t_clamp_zero();
    cfg_nodes = 8'd0; cfg_half = 8'd1; cfg_node_dly = 8'd1;
    tx_mem[0] = 31'h0F0F_0F0F;
    clear_mon(2);
    send_words(1);
    wait_idle();
    chk("R3", rx_cnt, 1, "zero node count acts as one");
    chk("R4", latches, 1, "latch after single word");
  endtask

  task automatic t_clamp_max();
    cfg_nodes = 8'd255; cfg_half = 8'd1; cfg_node_dly = 8'd0;
    for (int i = 0; i < 250; i++) tx_mem[i] = 31'(i * 7919 + 13) & 31'h3FFF_FFFF;
    clear_mon(2);
    send_words(250);
    wait_idle();
    chk("R3", rises, 250 * 31, "rising edges, clamped chain");
    chk("R3", latches, 1, "latch count, clamped chain");
    chk("R1", word_mismatches(250), 0, "bits, clamped chain");
  endtask

  task automatic t_cfg_mid();
    cfg_nodes = 8'd2; cfg_half = 8'd2; cfg_node_dly = 8'd0;
    tx_mem[0] = 31'h1357_9BDF;
    tx_mem[1] = 31'h0246_8ACE;
    clear_mon(4);
    in_word = tx_mem[0]; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_half = 8'd5; cfg_nodes = 8'd1; cfg_node_dly = 8'd9;
    tx_mem[0] = tx_mem[1];
    send_words(1);
    wait_idle();
    chk("R12", spacing_err, 0, "period kept after mid-frame change");
    chk("R12", rx_cnt, 2, "node count kept after mid-frame change");
  endtask

  task automatic t_restart();
    en_req = 1'b1; cfg_half = 8'd2;
    repeat (2) @(negedge clk);
    clear_mon(0);
    restart_req = 1'b1;
    @(negedge clk);
    restart_req = 1'b0;
    wait_idle();
    chk("R8", rs_rises, 1, "sclk rises with outputs blanked");
    chk("R8", rises, 1, "total sclk rises in restart");
    chk("R8", oe_hi_cycles, 6, "blanked cycles, H=2");
    chk("R8", latches, 0, "latch during restart");
    chk("R8", oe_n, 0, "oe_n after restart");
  endtask

  task automatic t_restart_busy();
    cfg_nodes = 8'd1; cfg_half = 8'd2; cfg_node_dly = 8'd0; en_req = 1'b1;
    tx_mem[0] = 31'h2222_4444;
    clear_mon(4);
    send_words(1);
    repeat (5) @(negedge clk);
    restart_req = 1'b1;
    @(negedge clk);
    restart_req = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R10", rises, 31, "sclk rises with restart during frame");
    chk("R10", oe_hi_cycles, 0, "oe_n high cycles with restart during frame");
  endtask

  task automatic t_enable();
    en_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", oe_n, 1, "oe_n with enable off");
    en_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", oe_n, 0, "oe_n with enable on");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_clamp_zero();
    t_clamp_max();
    t_cfg_mid();
    t_restart();
    t_restart_busy();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule